// File: doc/BRIEF.md
# Serial Flash Command Receiver

This block is the single-line serial front end of a flash device. It runs entirely in the system clock domain. It oversamples the chip-select, serial-clock and data-in pins through synchronizer chains and detects their edges. Within each frame bounded by chip select low, it shifts in bits MSB first on every rising serial clock. The first byte is presented as the opcode, and every later byte is presented with an index that counts from zero.

When chip select is released, the block emits a one-cycle frame-end pulse. The pulse carries an alignment flag and a verdict. The verdict says whether the command executor should run the command (commit) or throw it away (drop). Opcodes that change device state need a frame that ended on a byte boundary. While the device reports busy, only the status-read and reset opcodes get through. All other opcodes are flagged as ignored, their trailing bytes are suppressed, and they are dropped.

Top module: `spi_cmd_rx`

## Requirements
- R1: After reset, every output strobe and flag (op_valid_o, op_ignored_o, byte_valid_o, frame_end_o, frame_aligned_o, cmd_commit_o, cmd_drop_o) is 0.
- R2: The first 8 bits sampled on rising serial clock edges after chip select falls form the opcode, MSB first. It is shown on op_o with a one-cycle op_valid_o.
- R3: Each later group of 8 bits is shown on byte_o, MSB first, with a one-cycle byte_valid_o. byte_idx_o is 0 for the first byte after the opcode and rises by one per byte.
- R4: Serial clock edges while chip select is high shift nothing. Each falling chip select starts a fresh bit count.
- R5: A rising chip select yields exactly one frame_end_o pulse. frame_aligned_o is 1 exactly when the number of bits in the frame is a multiple of 8.
- R6: The state-changing opcodes 0x06, 0x04, 0x01, 0x02, 0x10 and 0xD8 get cmd_commit_o only on an aligned frame. On an unaligned frame they get cmd_drop_o.
- R7: Any other accepted opcode gets cmd_commit_o at frame end whether or not the frame is aligned.
- R8: If busy_i is 1 when the opcode completes and the opcode is neither 0x05 nor 0xFF, then op_ignored_o pulses with op_valid_o, no byte_valid_o follows in that frame, and the frame ends with cmd_drop_o.
- R9: Opcodes 0x05 and 0xFF are accepted while busy: op_ignored_o stays 0, bytes are delivered, and the frame commits.
- R10: A frame that ends before a full opcode has arrived gives frame_end_o with neither cmd_commit_o nor cmd_drop_o.
- R11: cmd_commit_o and cmd_drop_o are never 1 together, and neither is 1 outside a frame_end_o cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cs_n_i | input | 1 | Chip select, active low |
| sclk_i | input | 1 | Serial clock pin |
| sdi_i | input | 1 | Serial data-in pin |
| busy_i | input | 1 | Device busy status |
| op_valid_o | output | 1 | Opcode strobe |
| op_o | output | 8 | Current opcode |
| op_ignored_o | output | 1 | Opcode rejected because busy |
| byte_valid_o | output | 1 | Trailing byte strobe |
| byte_o | output | 8 | Trailing byte value |
| byte_idx_o | output | IDX_W | Index of trailing byte |
| frame_end_o | output | 1 | Chip-select release pulse |
| frame_aligned_o | output | 1 | Frame had a whole number of bytes |
| cmd_commit_o | output | 1 | Execute the command |
| cmd_drop_o | output | 1 | Discard the command |

## Verification
The assertions assume that each serial clock level and each chip-select level lasts several system clocks, so that no edge is lost in the synchronizers. They also assume that busy_i holds steady while an opcode completes. The stimulus keeps each serial clock phase 4 system clocks long and leaves idle gaps around chip-select edges. It changes busy only between frames. Stray serial clock pulses while deselected, frames cut short before the opcode, empty frames and unaligned tails are all driven within these limits.

// File: rtl/spi_cmd_rx_pkg.sv
package spi_cmd_rx_pkg;
  localparam int BYTE_W = 8;
  localparam logic [7:0] OP_RD_STATUS = 8'h05;
  localparam logic [7:0] OP_RESET     = 8'hFF;

  // opcodes that alter device state need a byte-aligned frame end
  function automatic logic op_needs_align(input logic [7:0] op);
    case (op)
      8'h06, 8'h04, 8'h01, 8'h02, 8'h10, 8'hD8: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic op_busy_ok(input logic [7:0] op);
    return (op == OP_RD_STATUS) || (op == OP_RESET);
  endfunction
endpackage

// File: rtl/spi_in_sync.sv
module spi_in_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cs_n_i,
  input  logic sclk_i,
  input  logic sdi_i,
  output logic cs_n_o,
  output logic sdi_o,
  output logic cs_fall_o,
  output logic cs_rise_o,
  output logic sclk_rise_o
);
  localparam int NSIG = 3;
  localparam int CW = NSIG * STAGES;
  localparam logic [NSIG-1:0] RST_VAL = 3'b001; // cs idles high

  logic [CW-1:0]   chain_q;
  logic [NSIG-1:0] sync_s, prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      chain_q <= {STAGES{RST_VAL}};
      prev_q  <= RST_VAL;
    end else begin
      chain_q <= {chain_q[CW-NSIG-1:0], sdi_i, sclk_i, cs_n_i};
      prev_q  <= sync_s;
    end
  end

  assign sync_s      = chain_q[CW-1 -: NSIG];
  assign cs_n_o      = sync_s[0];
  assign sdi_o       = sync_s[2];
  assign cs_fall_o   = !sync_s[0] && prev_q[0];
  assign cs_rise_o   = sync_s[0] && !prev_q[0];
  assign sclk_rise_o = sync_s[1] && !prev_q[1];
endmodule

// File: rtl/spi_bit_shifter.sv
module spi_bit_shifter
  import spi_cmd_rx_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_n_i,
  input  logic              sclk_rise_i,
  input  logic              sdi_i,
  output logic              byte_done_o,
  output logic [BYTE_W-1:0] byte_o,
  output logic              first_o,
  output logic              partial_o
);
  localparam int BIT_W = $clog2(BYTE_W);
  localparam logic [BIT_W-1:0] LAST = BIT_W'(BYTE_W - 1);

  logic [BIT_W-1:0]  bit_pos_q;
  logic [BYTE_W-2:0] sh_q;
  logic              got_first_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bit_pos_q   <= '0;
      sh_q        <= '0;
      got_first_q <= 1'b0;
      byte_done_o <= 1'b0;
      byte_o      <= '0;
      first_o     <= 1'b0;
    end else if (cs_n_i) begin
      bit_pos_q   <= '0;
      got_first_q <= 1'b0;
      byte_done_o <= 1'b0;
    end else if (sclk_rise_i) begin
      sh_q <= {sh_q[BYTE_W-3:0], sdi_i};
      if (bit_pos_q == LAST) begin
        bit_pos_q   <= '0;
        byte_done_o <= 1'b1;
        byte_o      <= {sh_q, sdi_i};
        first_o     <= !got_first_q;
        got_first_q <= 1'b1;
      end else begin
        bit_pos_q   <= bit_pos_q + 1'b1;
        byte_done_o <= 1'b0;
      end
    end else begin
      byte_done_o <= 1'b0;
    end
  end

  assign partial_o = (bit_pos_q != '0);
endmodule

// File: rtl/spi_frame_ctl.sv
module spi_frame_ctl
  import spi_cmd_rx_pkg::*;
#(
  parameter int IDX_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              byte_done_i,
  input  logic [BYTE_W-1:0] byte_i,
  input  logic              first_i,
  input  logic              partial_i,
  input  logic              cs_rise_i,
  input  logic              busy_i,
  output logic              op_valid_o,
  output logic [7:0]        op_o,
  output logic              op_ignored_o,
  output logic              byte_valid_o,
  output logic [BYTE_W-1:0] byte_o,
  output logic [IDX_W-1:0]  byte_idx_o,
  output logic              frame_end_o,
  output logic              frame_aligned_o,
  output logic              cmd_commit_o,
  output logic              cmd_drop_o
);
  localparam logic [IDX_W-1:0] IDX_MAX = {IDX_W{1'b1}};

  logic [7:0]       op_q;
  logic             have_op_q, ign_q;
  logic [IDX_W-1:0] idx_q;
  logic             ign_now, commit_now;

  assign op_valid_o   = byte_done_i && first_i;
  assign ign_now      = busy_i && !op_busy_ok(byte_i);
  assign op_ignored_o = op_valid_o && ign_now;
  assign op_o         = op_valid_o ? byte_i : op_q;
  assign byte_valid_o = byte_done_i && !first_i && !ign_q;
  assign byte_o       = byte_i;
  assign byte_idx_o   = idx_q;
  assign commit_now   = have_op_q && !ign_q && (!partial_i || !op_needs_align(op_q));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      op_q            <= '0;
      have_op_q       <= 1'b0;
      ign_q           <= 1'b0;
      idx_q           <= '0;
      frame_end_o     <= 1'b0;
      frame_aligned_o <= 1'b0;
      cmd_commit_o    <= 1'b0;
      cmd_drop_o      <= 1'b0;
    end else if (cs_rise_i) begin
      frame_end_o     <= 1'b1;
      frame_aligned_o <= !partial_i;
      cmd_commit_o    <= commit_now;
      cmd_drop_o      <= have_op_q && !commit_now;
      have_op_q       <= 1'b0;
      ign_q           <= 1'b0;
      idx_q           <= '0;
    end else begin
      frame_end_o     <= 1'b0;
      frame_aligned_o <= 1'b0;
      cmd_commit_o    <= 1'b0;
      cmd_drop_o      <= 1'b0;
      if (op_valid_o) begin
        op_q      <= byte_i;
        have_op_q <= 1'b1;
        ign_q     <= ign_now;
        idx_q     <= '0;
      end else if (byte_valid_o && idx_q != IDX_MAX) begin
        idx_q <= idx_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/spi_cmd_rx.sv
module spi_cmd_rx
  import spi_cmd_rx_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int IDX_W       = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cs_n_i,
  input  logic             sclk_i,
  input  logic             sdi_i,
  input  logic             busy_i,
  output logic             op_valid_o,
  output logic [7:0]       op_o,
  output logic             op_ignored_o,
  output logic             byte_valid_o,
  output logic [7:0]       byte_o,
  output logic [IDX_W-1:0] byte_idx_o,
  output logic             frame_end_o,
  output logic             frame_aligned_o,
  output logic             cmd_commit_o,
  output logic             cmd_drop_o
);
  logic cs_n_s, sdi_s, cs_fall, cs_rise, sclk_rise;
  logic byte_done, first, partial;
  logic [BYTE_W-1:0] byte_w;

  spi_in_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i, .rst_ni, .cs_n_i, .sclk_i, .sdi_i,
    .cs_n_o(cs_n_s), .sdi_o(sdi_s), .cs_fall_o(cs_fall),
    .cs_rise_o(cs_rise), .sclk_rise_o(sclk_rise)
  );

  spi_bit_shifter u_shift (
    .clk_i, .rst_ni, .cs_n_i(cs_n_s), .sclk_rise_i(sclk_rise && !cs_fall),
    .sdi_i(sdi_s), .byte_done_o(byte_done), .byte_o(byte_w),
    .first_o(first), .partial_o(partial)
  );

  spi_frame_ctl #(.IDX_W(IDX_W)) u_ctl (
    .clk_i, .rst_ni, .byte_done_i(byte_done), .byte_i(byte_w),
    .first_i(first), .partial_i(partial), .cs_rise_i(cs_rise),
    .busy_i, .op_valid_o, .op_o, .op_ignored_o, .byte_valid_o, .byte_o,
    .byte_idx_o, .frame_end_o, .frame_aligned_o, .cmd_commit_o, .cmd_drop_o
  );
endmodule

// File: rtl/spi_cmd_rx_chk.sv
module spi_cmd_rx_chk
  import spi_cmd_rx_pkg::*;
#(
  parameter int IDX_W = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             cs_n_i,
  input logic             busy_i,
  input logic             op_valid_o,
  input logic [7:0]       op_o,
  input logic             op_ignored_o,
  input logic             byte_valid_o,
  input logic [IDX_W-1:0] byte_idx_o,
  input logic             frame_end_o,
  input logic             frame_aligned_o,
  input logic             cmd_commit_o,
  input logic             cmd_drop_o
);
  // R11
  verdict_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_commit_o || cmd_drop_o) |-> (frame_end_o && !(cmd_commit_o && cmd_drop_o)));
  // R5
  frame_end_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_end_o |=> !frame_end_o);
  // R5
  frame_end_cs_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_end_o |-> cs_n_i);
  // R6
  unaligned_commit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_commit_o && !frame_aligned_o) |-> !op_needs_align(op_o));
  // R8
  ignored_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_ignored_o |-> (op_valid_o && busy_i));
  // R9
  allowed_op_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_ignored_o |-> !op_busy_ok(op_o));
  // R3
  strobe_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(op_valid_o && byte_valid_o));
  // R3
  idx_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_valid_o && !op_ignored_o) |=> (byte_idx_o == '0));
endmodule

bind spi_cmd_rx spi_cmd_rx_chk #(.IDX_W(IDX_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .cs_n_i(cs_n_i), .busy_i(busy_i),
  .op_valid_o(op_valid_o), .op_o(op_o), .op_ignored_o(op_ignored_o),
  .byte_valid_o(byte_valid_o), .byte_idx_o(byte_idx_o),
  .frame_end_o(frame_end_o), .frame_aligned_o(frame_aligned_o),
  .cmd_commit_o(cmd_commit_o), .cmd_drop_o(cmd_drop_o)
);

// File: tb/tb_spi_cmd_rx.sv
`timescale 1ns/1ps
module tb_spi_cmd_rx;
  localparam int HP = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cs_n = 1'b1, sclk = 1'b0, sdi = 1'b0, busy = 1'b0;
  logic op_valid_o, op_ignored_o, byte_valid_o, frame_end_o;
  logic frame_aligned_o, cmd_commit_o, cmd_drop_o;
  logic [7:0] op_o, byte_o, byte_idx_o;

  always #10 clk = ~clk;

  spi_cmd_rx dut (
    .clk_i(clk), .rst_ni(rst_n), .cs_n_i(cs_n), .sclk_i(sclk), .sdi_i(sdi),
    .busy_i(busy), .op_valid_o, .op_o, .op_ignored_o, .byte_valid_o, .byte_o,
    .byte_idx_o, .frame_end_o, .frame_aligned_o, .cmd_commit_o, .cmd_drop_o
  );

  typedef struct {
    int         kind;   // 0 opcode, 1 byte, 2 frame end
    logic [7:0] d;
    logic [7:0] idx;
    logic       f1, f2, f3;
    string      req;
  } exp_t;

  exp_t q[$];
  int compared = 0, mismatched = 0;
  bit done = 0;

  function automatic logic needs_boundary(input logic [7:0] op);
    return op inside {8'h06, 8'h04, 8'h01, 8'h02, 8'h10, 8'hD8};
  endfunction

  task automatic cmp(input string req, input string what, input logic [7:0] act, input logic [7:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic pop_cmp(input int kind, input logic [7:0] d, input logic [7:0] idx,
                         input logic f1, input logic f2, input logic f3);
    exp_t e;
    if (q.size() == 0) begin
      compared++; mismatched++;
      $display("FAIL R11 unexpected event: actual kind %0d expected none", kind);
      return;
    end
    e = q.pop_front();
    cmp(e.req, "kind", 8'(kind), 8'(e.kind));
    if (kind != e.kind) return;
    if (kind == 0) begin
      cmp(e.req, "opcode", d, e.d);
      cmp(e.req, "ignored", {7'd0, f1}, {7'd0, e.f1});
    end else if (kind == 1) begin
      cmp(e.req, "byte", d, e.d);
      cmp(e.req, "index", idx, e.idx);
    end else begin
      cmp(e.req, "aligned", {7'd0, f1}, {7'd0, e.f1});
      cmp(e.req, "commit", {7'd0, f2}, {7'd0, e.f2});
      cmp(e.req, "drop", {7'd0, f3}, {7'd0, e.f3});
    end
  endtask

  // monitor
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (op_valid_o) pop_cmp(0, op_o, 8'd0, op_ignored_o, 1'b0, 1'b0);
      if (byte_valid_o) pop_cmp(1, byte_o, byte_idx_o, 1'b0, 1'b0, 1'b0);
      if (frame_end_o) pop_cmp(2, 8'd0, 8'd0, frame_aligned_o, cmd_commit_o, cmd_drop_o);
      if ((cmd_commit_o || cmd_drop_o) && !frame_end_o) begin
        compared++; mismatched++;
        $display("FAIL R11 verdict outside frame end: actual 1 expected 0");
      end
    end
  end

  task automatic wait_clk(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic send_bit(input logic b);
    sdi = b; wait_clk(HP);
    sclk = 1'b1; wait_clk(HP);
    sclk = 1'b0;
  endtask

  task automatic push(input int kind, input logic [7:0] d, input logic [7:0] idx,
                      input logic f1, input logic f2, input logic f3, input string req);
    exp_t e;
    e.kind = kind; e.d = d; e.idx = idx; e.f1 = f1; e.f2 = f2; e.f3 = f3; e.req = req;
    q.push_back(e);
  endtask

  // driver: frame with opcode, nb bytes from pl (MSB byte first), extra 1-bits
  task automatic run_frame(input logic [7:0] op, input int nb, input logic [31:0] pl,
                           input int extra, input logic bsy, input string req);
    logic ign, aligned, commit;
    ign     = bsy && !(op == 8'h05 || op == 8'hFF);
    aligned = (extra == 0);
    commit  = !ign && (aligned || !needs_boundary(op));
    push(0, op, 8'd0, ign, 1'b0, 1'b0, req);
    if (!ign) for (int i = 0; i < nb; i++) push(1, pl[31-8*i -: 8], 8'(i), 1'b0, 1'b0, 1'b0, req);
    push(2, 8'd0, 8'd0, aligned, commit, !commit, req);
    busy = bsy; wait_clk(2);
    cs_n = 1'b0; wait_clk(HP);
    for (int i = 7; i >= 0; i--) send_bit(op[i]);
    for (int b = 0; b < nb; b++)
      for (int i = 7; i >= 0; i--) send_bit(pl[31-8*b-(7-i)]);
    for (int i = 0; i < extra; i++) send_bit(1'b1);
    wait_clk(HP);
    cs_n = 1'b1; wait_clk(10);
  endtask

  task automatic short_frame(input int nbits, input string req);
    push(2, 8'd0, 8'd0, (nbits % 8) == 0, 1'b0, 1'b0, req);
    cs_n = 1'b0; wait_clk(HP);
    for (int i = 0; i < nbits; i++) send_bit(i[0]);
    wait_clk(HP);
    cs_n = 1'b1; wait_clk(10);
  endtask

  initial begin
    wait_clk(3);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    cmp("R1", "strobes", {1'b0, op_valid_o, op_ignored_o, byte_valid_o, frame_end_o,
        frame_aligned_o, cmd_commit_o, cmd_drop_o}, 8'd0);
    wait_clk(2);

    run_frame(8'h05, 0, 32'h0, 0, 1'b0, "R2");
    run_frame(8'h02, 3, 32'hA5_3C_0F_00, 0, 1'b0, "R3");
    run_frame(8'h02, 2, 32'h81_7E_00_00, 3, 1'b0, "R6");
    run_frame(8'h06, 0, 32'h0, 5, 1'b0, "R6");
    run_frame(8'hD8, 3, 32'h00_12_34_00, 0, 1'b0, "R6");
    run_frame(8'h03, 1, 32'hC3_00_00_00, 5, 1'b0, "R7");
    run_frame(8'h9F, 4, 32'hDE_AD_BE_EF, 0, 1'b0, "R7");
    run_frame(8'hD8, 3, 32'h00_12_34_00, 0, 1'b1, "R8");
    run_frame(8'h03, 2, 32'h55_AA_00_00, 4, 1'b1, "R8");
    run_frame(8'h05, 1, 32'h3C_00_00_00, 0, 1'b1, "R9");
    run_frame(8'hFF, 0, 32'h0, 0, 1'b1, "R9");
    busy = 1'b0;
    short_frame(5, "R10");
    short_frame(0, "R10");
    short_frame(8 - 3, "R5");
    // R4: stray clocks while deselected must not shift
    for (int i = 0; i < 5; i++) send_bit(1'b1);
    wait_clk(10);
    run_frame(8'h10, 1, 32'h42_00_00_00, 0, 1'b0, "R4");
    wait_clk(20);
    // all expected events consumed
    cmp("R11", "pending", 8'(q.size()), 8'd0);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      compared++; mismatched++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule